// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block watches two clocks that are divided down from one fast source clock and drives an active-low warning pulse ahead of every rising edge at which both divided clocks rise together. It runs on the source clock itself and is given the two integer divide ratios, so it tracks the phase of both divided clocks directly instead of sampling them. The pulse is one period of the faster divided clock long and ends exactly on the common rising edge. Logic that has to act on a shared edge of two unrelated-looking clock frequencies can therefore prepare one fast period in advance.

The block is restarted by reset or by a one-cycle start strobe, issued together with the reset of the external dividers. Both divided clocks are then taken to be at a common rising edge in the cycle after the restart edge. The ratios are captured only at restart. Any ratio combination is handled, including integer ratios and equal ratios. With equal ratios every edge is shared, so the output stays low.

Top module: `coinc_sync_gen`

## Requirements
- R1: Count source cycles k from 0, the first cycle after a restart edge. Let Ra and Rc be the captured ratios, L their least common multiple and Rf the smaller of the two. Then sync_n is 0 in cycle k exactly when (k mod L) >= L - Rf, and 1 otherwise.
- R2: With unequal ratios, every low pulse on sync_n lasts exactly Rf consecutive source cycles.
- R3: With unequal ratios, the first high cycle after a pulse is a cycle k in which k mod Ra = 0 and k mod Rc = 0, which is a common rising edge.
- R4: When the two captured ratios are equal (1:1 included), sync_n is 0 in every cycle after the restart.
- R5: The faster clock is taken to be the one with the smaller ratio, whichever input carries it, so swapping div_a and div_c gives the same output.
- R6: A ratio input of 0 is treated as a ratio of 1.
- R7: div_a and div_c are captured only at an edge where rst or start is 1. Changing them at any other time has no effect on sync_n until the next restart.
- R8: A start (active-high, synchronous) realigns the block at any time, including in the middle of a pulse. The cycle after the start edge is cycle 0 of R1.
- R9: rst is synchronous and active-high and acts like start. After rst is released, sync_n follows R1 from cycle 0. With unequal ratios it is therefore 1 in cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock that the monitored clocks are divided from |
| rst | input | 1 | Synchronous active-high reset; also captures the ratios and realigns the block |
| start | input | 1 | One-cycle realign strobe, issued together with the divider reset |
| div_a | input | RATIO_W | Divide ratio of the first monitored clock |
| div_c | input | RATIO_W | Divide ratio of the second monitored clock |
| sync_n | output | 1 | Active-low pulse covering the fast period before each common rising edge |

## Verification
The bench goes after equal ratios, where a design that only reacts to one edge would pulse once per period instead of holding the output low. It also covers ratio 1 against larger ratios, where an off-by-one in the look-ahead would shift the pulse off the common edge by a cycle. Swapped and zero ratios are included: picking the wrong clock as the faster one would give pulses of the slow width, and leaving 0 unclamped would freeze the phase counters. Mid-pulse restarts and mid-run ratio changes are also exercised. A design that failed to realign would continue the old pulse, and a design that did not latch the ratios would change the pulse pattern without a restart.

// File: rtl/coinc_sync_pkg.sv
package coinc_sync_pkg;

    // Internal width of ratio and phase arithmetic; the top's RATIO_W must not exceed it.
    localparam int unsigned PW = 16;

    typedef logic [PW-1:0] ratio_t;

    // Captured ratio pair, ordered so that the faster clock (smaller ratio) comes first.
    typedef struct packed {
        ratio_t rf;   // ratio of the faster monitored clock
        ratio_t rs;   // ratio of the slower monitored clock
    } ratio_cfg_t;

    // A ratio of zero is meaningless for a divider; it is run as divide-by-one.
    function automatic ratio_t clamp_ratio(input ratio_t r);
        return (r == '0) ? ratio_t'(1) : r;
    endfunction

    // Clamp both ratios and order them by speed.
    function automatic ratio_cfg_t order_ratios(input ratio_t a, input ratio_t c);
        ratio_cfg_t cfg;
        ratio_t     ra;
        ratio_t     rc;
        ra = clamp_ratio(a);
        rc = clamp_ratio(c);
        if (ra <= rc) begin
            cfg.rf = ra;
            cfg.rs = rc;
        end else begin
            cfg.rf = rc;
            cfg.rs = ra;
        end
        return cfg;
    endfunction

    // The next rising edge of the fast clock lies (rf - pf) cycles ahead. It is
    // shared with the slow clock when the slow phase reaches rs exactly there.
    // The sum lies in 1 .. 2*rs-1, so the only multiple of rs it can hit is rs.
    function automatic logic next_fast_edge_shared(input ratio_t ps, input ratio_t pf,
                                                   input ratio_t rs, input ratio_t rf);
        logic [PW:0] ahead;
        ahead = {1'b0, ps} + {1'b0, rf} - {1'b0, pf};
        return ahead == {1'b0, rs};
    endfunction

endpackage

// File: rtl/coinc_sync_cfg.sv
module coinc_sync_cfg
    import coinc_sync_pkg::*;
#(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk,
    input  logic               restart,
    input  logic [RATIO_W-1:0] div_a,
    input  logic [RATIO_W-1:0] div_c,
    output ratio_cfg_t         cfg_d,
    output ratio_cfg_t         cfg_q
);

    // Ratios are taken only at a restart; otherwise the captured pair is held.
    always_comb begin
        if (restart) begin
            cfg_d = order_ratios(ratio_t'(div_a), ratio_t'(div_c));
        end else begin
            cfg_d = cfg_q;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/coinc_phase_ctr.sv
module coinc_phase_ctr
    import coinc_sync_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  ratio_t ratio,
    output ratio_t ph_d,
    output ratio_t ph_q
);

    // Phase 0 marks a rising edge of the divided clock this counter tracks.
    always_comb begin
        if (restart) begin
            ph_d = '0;
        end else if (ph_q + 1'b1 >= ratio) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

endmodule

// File: rtl/coinc_pulse_out.sv
module coinc_pulse_out
    import coinc_sync_pkg::*;
(
    input  logic       clk,
    input  ratio_t     ph_fast_d,
    input  ratio_t     ph_slow_d,
    input  ratio_cfg_t cfg_d,
    output logic       sync_n
);

    // Decided from next-cycle state, so the registered output lines up with
    // the phases of the cycle it is shown in.
    always_ff @(posedge clk) begin
        sync_n <= ~next_fast_edge_shared(ph_slow_d, ph_fast_d, cfg_d.rs, cfg_d.rf);
    end

endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen
    import coinc_sync_pkg::*;
#(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [RATIO_W-1:0] div_a,
    input  logic [RATIO_W-1:0] div_c,
    output logic               sync_n
);

    localparam int unsigned NCH      = 2;  // channel 0: fast clock, channel 1: slow clock
    localparam int unsigned CH_FAST  = 0;
    localparam int unsigned CH_SLOW  = 1;

    logic       restart;
    ratio_cfg_t cfg_d;
    ratio_cfg_t cfg_q;
    ratio_t     ch_ratio [NCH];
    ratio_t     ph_d     [NCH];
    ratio_t     ph_q     [NCH];

    assign restart = rst | start;

    coinc_sync_cfg #(
        .RATIO_W (RATIO_W)
    ) u_cfg (
        .clk     (clk),
        .restart (restart),
        .div_a   (div_a),
        .div_c   (div_c),
        .cfg_d   (cfg_d),
        .cfg_q   (cfg_q)
    );

    assign ch_ratio[CH_FAST] = cfg_q.rf;
    assign ch_ratio[CH_SLOW] = cfg_q.rs;

    for (genvar g = 0; g < NCH; g++) begin : g_phase
        coinc_phase_ctr u_ph (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .ratio   (ch_ratio[g]),
            .ph_d    (ph_d[g]),
            .ph_q    (ph_q[g])
        );
    end

    coinc_pulse_out u_out (
        .clk       (clk),
        .ph_fast_d (ph_d[CH_FAST]),
        .ph_slow_d (ph_d[CH_SLOW]),
        .cfg_d     (cfg_d),
        .sync_n    (sync_n)
    );

endmodule

// File: rtl/coinc_sync_chk.sv
module coinc_sync_chk
    import coinc_sync_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       sync_n,
    input ratio_cfg_t cfg_q,
    input ratio_t     ph_fast,
    input ratio_t     ph_slow
);

    logic [PW:0] low_len;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            low_len <= '0;
        end else if (!sync_n) begin
            low_len <= low_len + 1'b1;
        end else begin
            low_len <= '0;
        end
    end

    // R2
    width_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_n && !$past(sync_n) && !$past(rst) && !$past(start))
        |-> (low_len == {1'b0, cfg_q.rf}));

    // R3
    edge_align_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_n && !$past(sync_n) && !$past(rst) && !$past(start))
        |-> (ph_fast == '0 && ph_slow == '0));

    // R4
    flat_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rf == cfg_q.rs) |-> !sync_n);

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_fast < cfg_q.rf) && (ph_slow < cfg_q.rs));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cfg_q));

endmodule

bind coinc_sync_gen coinc_sync_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .sync_n  (sync_n),
    .cfg_q   (cfg_q),
    .ph_fast (ph_q[0]),
    .ph_slow (ph_q[1])
);

// File: tb/sim_coinc_sync_gen.sv
`timescale 1ns/1ps
module sim_coinc_sync_gen;

    localparam int unsigned RATIO_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [RATIO_W-1:0] div_a = 8'd2;
    logic [RATIO_W-1:0] div_c = 8'd3;
    logic               sync_n;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    int unsigned cyc     = 0;
    bit          done    = 1'b0;

    always #4 clk = ~clk;

    coinc_sync_gen #(.RATIO_W(RATIO_W)) u0 (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .div_a  (div_a),
        .div_c  (div_c),
        .sync_n (sync_n)
    );

    function automatic int clampr(int r);
        return (r == 0) ? 1 : r;
    endfunction

    function automatic int lcm_of(int a, int c);
        int hi = (a > c) ? a : c;
        int lo = (a > c) ? c : a;
        int m  = hi;
        while (m % lo != 0) m += hi;
        return m;
    endfunction

    // Expected level from R1, written from the coincidence interval.
    function automatic logic exp_level(int k, int a, int c);
        int ra = clampr(a);
        int rc = clampr(c);
        int l  = lcm_of(ra, rc);
        int rf = (ra < rc) ? ra : rc;
        return ((k % l) >= (l - rf)) ? 1'b0 : 1'b1;
    endfunction

    task automatic check(string tag, int actual, int expected, int k);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, k, actual, expected);
        end
    endtask

    // Restart (via rst or start) with ratios a,c, then check n cycles.
    // At cycle chg the inputs change to na,nc, which must be ignored (R7).
    task automatic run(string tag, bit by_rst, int a, int c, int n, int chg, int na, int nc);
        int ra = clampr(a);
        int rc = clampr(c);
        int rf = (ra < rc) ? ra : rc;
        int run_len = 0;
        logic prev = 1'b1;
        @(negedge clk);
        div_a = RATIO_W'(a);
        div_c = RATIO_W'(c);
        if (by_rst) begin
            rst = 1'b1;
            repeat (3) @(posedge clk);
        end else begin
            start = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        rst   = 1'b0;
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k == chg) begin
                div_a = RATIO_W'(na);
                div_c = RATIO_W'(nc);
            end
            check((k >= chg) ? "R7" : tag, int'(sync_n), int'(exp_level(k, a, c)), k);
            if (ra != rc) begin
                if (!sync_n) run_len++;
                if (sync_n && !prev) begin
                    check("R2", run_len, rf, k);
                    check("R3", int'((k % ra == 0) && (k % rc == 0)), 1, k);
                    run_len = 0;
                end
            end
            prev = sync_n;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Watchdog: an expired run counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 200000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd2977);
        // R9: reset state, unequal ratios -> high in cycle 0
        run("R9", 1'b1, 2, 3, 20, 1000, 0, 0);
        // R1: ordinary and integer ratios
        run("R1", 1'b0, 2, 1, 12, 1000, 0, 0);
        run("R1", 1'b0, 3, 1, 15, 1000, 0, 0);
        run("R1", 1'b0, 3, 2, 20, 1000, 0, 0);
        run("R1", 1'b0, 4, 1, 16, 1000, 0, 0);
        run("R1", 1'b0, 4, 3, 30, 1000, 0, 0);
        run("R1", 1'b0, 6, 1, 24, 1000, 0, 0);
        run("R1", 1'b0, 12, 8, 60, 1000, 0, 0);
        // R5: swapped inputs give the same pattern
        run("R5", 1'b0, 1, 6, 24, 1000, 0, 0);
        run("R5", 1'b0, 3, 4, 30, 1000, 0, 0);
        run("R5", 1'b0, 8, 12, 60, 1000, 0, 0);
        // R4: equal ratios hold the output low
        run("R4", 1'b0, 1, 1, 10, 1000, 0, 0);
        run("R4", 1'b0, 5, 5, 20, 1000, 0, 0);
        run("R4", 1'b1, 4, 4, 12, 1000, 0, 0);
        // R6: zero ratio treated as one
        run("R6", 1'b0, 0, 4, 16, 1000, 0, 0);
        run("R6", 1'b0, 5, 0, 16, 1000, 0, 0);
        run("R6", 1'b0, 0, 0, 8, 1000, 0, 0);
        // R7: mid-run ratio changes are ignored
        run("R7", 1'b0, 3, 4, 40, 5, 7, 2);
        run("R7", 1'b0, 2, 2, 20, 3, 5, 3);
        // R8: restart in the middle of a pulse (2:3 is low at cycles 4 and 5)
        run("R8", 1'b0, 2, 3, 5, 1000, 0, 0);
        run("R8", 1'b0, 3, 4, 24, 1000, 0, 0);
        run("R8", 1'b0, 4, 4, 3, 1000, 0, 0);
        run("R8", 1'b0, 2, 5, 22, 1000, 0, 0);
        // R1: constrained random ratios and run lengths
        for (int i = 0; i < 40; i++) begin
            int a = int'($urandom_range(12, 0));
            int c = int'($urandom_range(12, 1));
            int l = lcm_of(clampr(a), clampr(c));
            int n = 2 * l + int'($urandom_range(6, 0));
            int chg = (i % 3 == 0) ? int'($urandom_range(n - 1, 0)) : 100000;
            run((clampr(a) == clampr(c)) ? "R4" : "R1", (i % 7 == 0), a, c, n, chg,
                int'($urandom_range(12, 1)), int'($urandom_range(12, 1)));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule